// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two thresholds that a FIFO's programmable flags compare against: the empty offset, which sets how few stored words count as almost empty, and the full offset, which sets how few free locations count as almost full. Both values drive the flag comparators continuously on `empty_ofs` and `full_ofs`. The FIFO storage and its flag comparators are separate blocks.

A synchronous master reset samples three strap inputs: the load pin and a two-bit flag select. Together they choose one of eight default offset pairs. The load strap also fixes whether the offsets are later rewritten in parallel, one word per write, or in serial, one bit per write. An interleave strap latched at the same time sets how offset bits map onto the data bus in parallel transfers. Once master reset is over, the load pin acts as an access gate. With it high, write strobes update the offsets instead of FIFO memory, and read strobes return the offsets on the read bus. A partial reset restarts the write and read sequences and keeps the offsets and the latched modes. Both ports run on one clock.

Top module: `flag_offset_loader`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `empty_ofs`, `full_ofs` and `rd_data` are all zero.
- R2: On a clock edge with `mrst` high, both offsets load the default 2^(k+3)-1, where k = {cfg_ld, flag_sel[1], flag_sel[0]} with cfg_ld as the MSB. This gives 7 for k=0 and 1023 for k=7. The new value is visible right after that edge.
- R3: The `cfg_ld` value sampled at master reset selects the programming method: 1 means parallel and 0 means serial. This method and the interleave setting hold until the next master reset.
- R4: In parallel mode, each edge with `cfg_ld` and `wr_en` high writes the offset taken from `din` into the empty offset and then into the full offset, alternating. The value is visible after that edge, and `ser_in` is ignored.
- R5: In serial mode, each edge with `cfg_ld` and `wr_en` high stores `ser_in` into the next bit. The order is empty-offset bits 0 to OFS_W-1, then full-offset bits 0 to OFS_W-1, and then the sequence wraps to empty-offset bit 0. `din` is ignored in this mode.
- R6: An edge with `cfg_ld` and `rd_en` high places an offset on `rd_data`. The first read returns the empty offset, the next returns the full offset, and the sequence wraps back to the empty offset. `rd_data` holds its value on edges without such a read.
- R7: `wr_en` or `rd_en` with `cfg_ld` low changes neither the offsets nor `rd_data`.
- R8: With the interleave strap clear, offset bit i uses data bit i. With it set, offset bit i uses data bit i + floor(i/8), so bits 8, 17, 26 and so on are skipped. The same mapping applies to both writes and readback, and data bits not used by the mapping read back as zero.
- R9: A partial reset (`prst` high at an edge) keeps both offsets and the latched modes, clears `rd_data`, and restarts the write sequence, the read sequence and the serial bit position at the empty offset, bit 0.
- R10: `mrst` takes priority over `prst`, which takes priority over any access. During `mrst`, `cfg_ld` acts only as a strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mrst | input | 1 | Synchronous master reset; samples the straps and loads the defaults |
| prst | input | 1 | Synchronous partial reset; restarts the sequences and keeps the offsets |
| cfg_ld | input | 1 | Strap during master reset; offset access gate afterwards |
| flag_sel | input | 2 | Default-offset select strap |
| ilv_strap | input | 1 | Interleaved bit-layout strap for parallel transfers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| din | input | DATA_W | Parallel write data |
| ser_in | input | 1 | Serial offset data input |
| empty_ofs | output | OFS_W | Empty offset sent to the flag comparator |
| full_ofs | output | OFS_W | Full offset sent to the flag comparator |
| rd_data | output | DATA_W | Offset readback bus |

## Verification
Every result arrives one edge after its stimulus. A master reset, a parallel or serial write, or a partial reset changes `empty_ofs` and `full_ofs` on the same edge that samples it, and a readback shows on `rd_data` after the edge that took the read. The driver tasks hold each stimulus across exactly one rising edge and return inputs to idle at the following falling edge, so the offset checks run at that falling edge and see the post-edge state. For reads, the driver queues the expected word before the edge. A monitor records at the rising edge whether a read was taken, waits 1 ns, and then pops the queue and compares `rd_data`, so each readback is matched to the one edge that produced it.

// File: rtl/fol_pkg.sv
package fol_pkg;

  // Programming method latched at master reset
  typedef enum logic {
    PROG_SERIAL   = 1'b0,
    PROG_PARALLEL = 1'b1
  } prog_e;

  // Which offset the write or read sequence points at
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } osel_e;

  localparam int unsigned NUM_DFLT   = 8;
  localparam int unsigned DFLT_SHIFT = 3;

  function automatic osel_e osel_next(osel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/fol_strap.sv
module fol_strap
  import fol_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst,
  input  logic             cfg_ld,
  input  logic [1:0]       flag_sel,
  input  logic             ilv_strap,
  output prog_e            mode,
  output logic             ilv,
  output logic [OFS_W-1:0] dflt_ofs
);

  localparam int unsigned IDX_W = $clog2(NUM_DFLT);

  logic [OFS_W-1:0] tbl [NUM_DFLT];
  logic [IDX_W-1:0] idx;
  prog_e            mode_q, mode_d;
  logic             ilv_q, ilv_d;

  // Default table: 2^(k+shift)-1 for each entry
  for (genvar k = 0; k < NUM_DFLT; k++) begin : g_dflt
    assign tbl[k] = OFS_W'((1 << (k + DFLT_SHIFT)) - 1);
  end

  assign idx      = {cfg_ld, flag_sel};
  assign dflt_ofs = tbl[idx];

  always_comb begin
    mode_d = mode_q;
    ilv_d  = ilv_q;
    if (mrst) begin
      mode_d = cfg_ld ? PROG_PARALLEL : PROG_SERIAL;
      ilv_d  = ilv_strap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PROG_SERIAL;
      ilv_q  <= 1'b0;
    end else if (mrst) begin
      mode_q <= mode_d;
      ilv_q  <= ilv_d;
    end
  end

  assign mode = mode_q;
  assign ilv  = ilv_q;

  // R3: latched modes only move on a master reset
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst |=> ($stable(mode_q) && $stable(ilv_q)));

endmodule

// File: rtl/fol_ofs_regs.sv
module fol_ofs_regs
  import fol_pkg::*;
#(
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              wr_go,
  input  prog_e             mode,
  input  logic              ilv,
  input  logic [OFS_W-1:0]  dflt_ofs,
  input  logic [DATA_W-1:0] din,
  input  logic              ser_in,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);

  localparam int unsigned TOT_BITS = 2 * OFS_W;
  localparam int unsigned SW       = $clog2(TOT_BITS);
  localparam int unsigned IW       = $clog2(OFS_W);

  logic [OFS_W-1:0] n_q, n_d, m_q, m_d;
  osel_e            wsel_q, wsel_d;
  logic [SW-1:0]    sbit_q, sbit_d;
  logic             ofs_en, ctl_en;
  logic [OFS_W-1:0] din_ofs;
  logic             in_lo, last_bit;
  logic [SW-1:0]    boff;
  logic [IW-1:0]    bidx;

  // Parallel extraction: flat or one skipped slot after every 8 bits
  always_comb begin
    din_ofs = '0;
    for (int i = 0; i < OFS_W; i++) begin
      din_ofs[i] = ilv ? din[i + i / 8] : din[i];
    end
  end

  assign in_lo    = (sbit_q < SW'(OFS_W));
  assign boff     = in_lo ? sbit_q : (sbit_q - SW'(OFS_W));
  assign bidx     = boff[IW-1:0];
  assign last_bit = (sbit_q == SW'(TOT_BITS - 1));

  always_comb begin
    n_d    = n_q;
    m_d    = m_q;
    wsel_d = wsel_q;
    sbit_d = sbit_q;
    ofs_en = 1'b0;
    ctl_en = 1'b0;
    if (mrst) begin
      n_d    = dflt_ofs;
      m_d    = dflt_ofs;
      wsel_d = SEL_EMPTY;
      sbit_d = '0;
      ofs_en = 1'b1;
      ctl_en = 1'b1;
    end else if (prst) begin
      wsel_d = SEL_EMPTY;
      sbit_d = '0;
      ctl_en = 1'b1;
    end else if (wr_go) begin
      ofs_en = 1'b1;
      ctl_en = 1'b1;
      if (mode == PROG_PARALLEL) begin
        if (wsel_q == SEL_EMPTY) n_d = din_ofs;
        else                     m_d = din_ofs;
        wsel_d = osel_next(wsel_q);
      end else begin
        if (in_lo) n_d[bidx] = ser_in;
        else       m_d[bidx] = ser_in;
        sbit_d = last_bit ? '0 : (sbit_q + SW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      m_q <= '0;
    end else if (ofs_en) begin
      n_q <= n_d;
      m_q <= m_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= SEL_EMPTY;
      sbit_q <= '0;
    end else if (ctl_en) begin
      wsel_q <= wsel_d;
      sbit_q <= sbit_d;
    end
  end

  assign empty_ofs = n_q;
  assign full_ofs  = m_q;

  // R7: without a write and without master reset the offsets hold
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst && !wr_go) |=> ($stable(n_q) && $stable(m_q)));

  // R5: a serial write touches at most one offset bit
  a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst && !prst && wr_go && mode == PROG_SERIAL)
      |=> ($countones({m_q, n_q} ^ $past({m_q, n_q})) <= 1));

  // R4: a parallel write updates only one of the two offsets
  a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst && !prst && wr_go && mode == PROG_PARALLEL)
      |=> ($stable(n_q) || $stable(m_q)));

  // R9: partial reset keeps both offsets
  a_r9_prst_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (prst && !mrst) |=> ($stable(n_q) && $stable(m_q)));

endmodule

// File: rtl/fol_readback.sv
module fol_readback
  import fol_pkg::*;
#(
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              rd_go,
  input  logic              ilv,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_data
);

  osel_e             rsel_q, rsel_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [OFS_W-1:0]  src;
  logic [DATA_W-1:0] placed;
  logic              upd_en;

  assign src = (rsel_q == SEL_EMPTY) ? empty_ofs : full_ofs;

  // Readback placement mirrors the write-side layout, unused bits zero
  always_comb begin
    placed = '0;
    for (int i = 0; i < OFS_W; i++) begin
      if (ilv) placed[i + i / 8] = src[i];
      else     placed[i]         = src[i];
    end
  end

  always_comb begin
    rsel_d = rsel_q;
    dat_d  = dat_q;
    upd_en = 1'b0;
    if (mrst || prst) begin
      rsel_d = SEL_EMPTY;
      dat_d  = '0;
      upd_en = 1'b1;
    end else if (rd_go) begin
      rsel_d = osel_next(rsel_q);
      dat_d  = placed;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= SEL_EMPTY;
      dat_q  <= '0;
    end else if (upd_en) begin
      rsel_q <= rsel_d;
      dat_q  <= dat_d;
    end
  end

  assign rd_data = dat_q;

  // R6: readback bus holds without a read or a reset
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst && !prst && !rd_go) |=> $stable(dat_q));

  // R9: partial or master reset clears the readback bus
  a_r9_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst || prst) |=> (dat_q == '0));

  if (OFS_W > 8 && DATA_W > 8) begin : g_slot_chk
    // R8: skipped slot of the interleaved layout reads back as zero
    a_r8_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ilv && !mrst && !prst && rd_go) |=> (dat_q[8] == 1'b0));
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import fol_pkg::*;
#(
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_ld,
  input  logic [1:0]        flag_sel,
  input  logic              ilv_strap,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  input  logic              ser_in,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_data
);

  prog_e            mode;
  logic             ilv;
  logic [OFS_W-1:0] dflt_ofs;
  logic             wr_go, rd_go;

  assign wr_go = cfg_ld & wr_en;
  assign rd_go = cfg_ld & rd_en;

  fol_strap #(.OFS_W(OFS_W)) u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst      (mrst),
    .cfg_ld    (cfg_ld),
    .flag_sel  (flag_sel),
    .ilv_strap (ilv_strap),
    .mode      (mode),
    .ilv       (ilv),
    .dflt_ofs  (dflt_ofs)
  );

  fol_ofs_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst      (mrst),
    .prst      (prst),
    .wr_go     (wr_go),
    .mode      (mode),
    .ilv       (ilv),
    .dflt_ofs  (dflt_ofs),
    .din       (din),
    .ser_in    (ser_in),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  fol_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rdbk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst      (mrst),
    .prst      (prst),
    .rd_go     (rd_go),
    .ilv       (ilv),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rd_data   (rd_data)
  );

  // R10: master reset wins over a same-cycle write
  a_r10_mrst_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst && wr_en) |=> (empty_ofs == full_ofs));

endmodule

// File: tb/sim_flag_offset_loader.sv
`timescale 1ns/1ps
module sim_flag_offset_loader;

  localparam int OW = 12;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n, mrst, prst, cfg_ld, ilv_strap, wr_en, rd_en, ser_in;
  logic [1:0]    flag_sel;
  logic [DW-1:0] din;
  logic [OW-1:0] empty_ofs, full_ofs;
  logic [DW-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [OW-1:0] mdl_n, mdl_m;
  bit            mdl_ilv, mdl_rp;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;

  flag_offset_loader #(.OFS_W(OW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .prst(prst), .cfg_ld(cfg_ld),
    .flag_sel(flag_sel), .ilv_strap(ilv_strap), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .ser_in(ser_in), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] lay(logic [OW-1:0] v, bit il);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < OW; i++) r[il ? i + i / 8 : i] = v[i];
    return r;
  endfunction

  function automatic logic [OW-1:0] dflt(int k);
    return OW'((1 << (k + 3)) - 1);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(string req, logic [OW-1:0] en, logic [OW-1:0] em);
    chk({req, " empty"}, DW'(empty_ofs), DW'(en));
    chk({req, " full"},  DW'(full_ofs),  DW'(em));
  endtask

  task automatic idle();
    mrst = 0; prst = 0; cfg_ld = 0; wr_en = 0; rd_en = 0;
    ser_in = 0; din = '0; flag_sel = 2'b00; ilv_strap = 0;
  endtask

  task automatic master(bit ld, logic [1:0] sel, bit il);
    @(negedge clk);
    mrst = 1; cfg_ld = ld; flag_sel = sel; ilv_strap = il; wr_en = 1;
    din = '1;
    @(negedge clk);
    idle();
    mdl_n = dflt({ld, sel}); mdl_m = mdl_n; mdl_ilv = il; mdl_rp = 0;
  endtask

  task automatic partial();
    @(negedge clk);
    prst = 1; cfg_ld = 1; wr_en = 1; din = '1;
    @(negedge clk);
    idle();
    mdl_rp = 0;
  endtask

  task automatic pwrite(logic [DW-1:0] d);
    @(negedge clk);
    cfg_ld = 1; wr_en = 1; din = d; ser_in = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic swrite(bit b);
    @(negedge clk);
    cfg_ld = 1; wr_en = 1; ser_in = b; din = '1;
    @(negedge clk);
    idle();
  endtask

  task automatic sshift(logic [OW-1:0] n, logic [OW-1:0] m);
    for (int i = 0; i < 2 * OW; i++) swrite(i < OW ? n[i] : m[i - OW]);
    mdl_n = n; mdl_m = m;
  endtask

  task automatic do_read(string req);
    exp_q.push_back(lay(mdl_rp ? mdl_m : mdl_n, mdl_ilv));
    tag_q.push_back(req);
    mdl_rp = ~mdl_rp;
    @(negedge clk);
    cfg_ld = 1; rd_en = 1;
    @(negedge clk);
    idle();
  endtask

  // Monitor: detects a taken read at the edge, compares 1 ns later
  always @(posedge clk) begin
    automatic logic fire = rst_n & cfg_ld & rd_en & ~mrst & ~prst;
    #1;
    if (fire) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6: actual %h expected <none queued>", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] hold;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 empty", DW'(empty_ofs), '0);
    chk("R1 full", DW'(full_ofs), '0);
    chk("R1 rd_data", rd_data, '0);
    rst_n = 1;

    // R2 defaults across several strap codes; R10 write during mrst ignored
    master(1'b1, 2'b11, 1'b0);
    chk_ofs("R2 k7 R10", 12'd1023, 12'd1023);
    master(1'b0, 2'b01, 1'b0);
    chk_ofs("R2 k1", 12'd15, 12'd15);
    master(1'b0, 2'b10, 1'b0);
    chk_ofs("R2 k2", 12'd31, 12'd31);

    // R3/R4 parallel: k=4 -> 127
    master(1'b1, 2'b00, 1'b0);
    chk_ofs("R2 k4", 12'd127, 12'd127);
    pwrite(36'hFFFF_F064);
    chk_ofs("R4 first to empty", 12'h064, 12'd127);
    pwrite(36'h0000_00C8);
    chk_ofs("R4 second to full", 12'h064, 12'h0C8);
    pwrite(36'h0000_0037);
    chk_ofs("R4 wrap R3", 12'h037, 12'h0C8);
    mdl_n = 12'h037; mdl_m = 12'h0C8;

    // R6 readback sequence with wrap
    do_read("R6 read empty");
    do_read("R6 read full");
    do_read("R6 read wrap");

    // R7 strobes without load gate
    hold = rd_data;
    @(negedge clk); wr_en = 1; rd_en = 1; din = 36'h0000_0ABC;
    @(negedge clk); idle();
    chk_ofs("R7 no write", 12'h037, 12'h0C8);
    chk("R7 rd_data held", rd_data, hold);

    // R9 partial reset in parallel mode
    partial();
    chk_ofs("R9 keep", 12'h037, 12'h0C8);
    chk("R9 rd cleared", rd_data, '0);
    pwrite(36'h0000_0111);
    chk_ofs("R9 seq restart R3", 12'h111, 12'h0C8);
    mdl_n = 12'h111;
    do_read("R9 read restart");

    // R5 serial mode: k=0 -> 7
    master(1'b0, 2'b00, 1'b0);
    chk_ofs("R2 k0", 12'd7, 12'd7);
    for (int i = 0; i < 5; i++) swrite(1'b0);
    chk_ofs("R5 partial shift", 12'd0, 12'd7);
    partial();
    chk_ofs("R9 serial keep", 12'd0, 12'd7);
    sshift(12'hA5C, 12'h3F1);
    chk_ofs("R5 full shift R9", 12'hA5C, 12'h3F1);
    swrite(1'b1);
    chk_ofs("R5 wrap to bit0", 12'hA5D, 12'h3F1);
    mdl_n = 12'hA5D;
    do_read("R6 serial read empty");
    do_read("R6 serial read full");

    // R8 interleaved layout, parallel, k=4
    master(1'b1, 2'b00, 1'b1);
    pwrite(lay(12'hABC, 1'b1) | 36'h0_0000_0100);
    chk_ofs("R8 ilv write", 12'hABC, 12'd127);
    pwrite(lay(12'h5A3, 1'b1));
    chk_ofs("R8 ilv write full", 12'hABC, 12'h5A3);
    mdl_n = 12'hABC; mdl_m = 12'h5A3;
    do_read("R8 ilv read empty");
    do_read("R8 ilv read full");

    // R3 modes persist across partial reset: still parallel + interleave
    partial();
    pwrite(lay(12'h0F0, 1'b1));
    chk_ofs("R3 mode kept", 12'h0F0, 12'h5A3);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule